// File: doc/BRIEF.md
# Opcode Dispatch Table Scanner

This block turns an 8-bit opcode into the 32-bit address of the routine that handles it. It looks the opcode up in a small table of 8-byte records kept in an on-chip memory. It reads one record per cycle through a 64-bit synchronous read port and compares each record's opcode byte with the requested opcode. The first record that matches decides the answer. The table has neither a header nor an end marker, so the number of records to scan comes only from the `entry_count_i` input. That count is captured when a request is accepted.

A request is offered with `req_valid_i` and accepted when `req_ready_o` is high. `req_ready_o` stays low while a scan is running and during the response cycle. The result comes back as a one-cycle `rsp_valid_o` pulse carrying the handler address or an error. An error is either a miss or a matching record whose zero bytes are not zero, which is treated as unsupported. Several opcodes may share one handler address; each of them resolves on its own. Anything beyond the lookup is left to the surrounding dispatcher: running the handler, filling the table, and any further decode of the spec byte.

Top module: `op_dispatch_scan`

## Requirements
- R1: A record is one 64-bit word. Bits 31:24 hold the opcode and bits 23:16 hold the spec byte. Bits 63:32 hold the handler address, with byte 4 as its least significant byte, and bits 15:0 are zero. On a clean match the handler is returned with `rsp_err_o`=0 and `rsp_unsup_o`=0.
- R2: After acceptance, record indices 0, 1, 2, … are read in ascending order, one per consecutive cycle. Reads stop after index count−1 or at the first match, so a record at index ≥ count never affects the result. A count above MAX_ENTRIES is clamped to MAX_ENTRIES.
- R3: When several records carry the requested opcode, the one with the lowest index decides the response.
- R4: Two distinct opcodes whose records hold the same handler address each return that address.
- R5: If the first matching record has a non-zero spec byte, or non-zero bits 15:0, the response has `rsp_err_o`=1, `rsp_unsup_o`=1 and handler 0.
- R6: If no record among the first count matches, the response has `rsp_err_o`=1, `rsp_unsup_o`=0 and handler 0. This covers an opcode that has no row, such as 0xf0, and a count of 0.
- R7: Cycles are counted from the acceptance cycle, which is cycle 0. A match at index k gives `rsp_valid_o` in cycle k+2. A miss gives it in cycle count+1, or cycle 1 when count is 0. `rsp_valid_o` is high for exactly one cycle.
- R8: `req_ready_o` is low from the cycle after acceptance through the response cycle and high again in the cycle after the response. A request offered meanwhile is not taken and does not alter the running lookup.
- R9: While `rst_ni` is low, `req_ready_o`=1, `rsp_valid_o`=0 and `mem_rd_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request offered |
| req_ready_o | output | 1 | Scanner idle, request taken this cycle if valid |
| req_opcode_i | input | 8 | Opcode to resolve |
| entry_count_i | input | CW ($clog2(MAX_ENTRIES+1)) | Number of records to scan, captured at acceptance |
| mem_rd_en_o | output | 1 | Record read strobe |
| mem_rd_addr_o | output | AW ($clog2(MAX_ENTRIES)) | Record index to read |
| mem_rd_data_i | input | 64 | Record word, one cycle after the read strobe |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_handler_o | output | 32 | Handler address, 0 on error |
| rsp_err_o | output | 1 | Miss or unsupported record |
| rsp_unsup_o | output | 1 | First match had non-zero spec or zero bytes |

## Verification
Two things can land in the same cycle: a new request arriving, and a scan or its response that is still in progress. To provoke this, the bench keeps `req_valid_i` high with a different opcode for the whole lookup. The run is correct when `req_ready_o` stays low in every cycle until the response, the response carries the handler of the first opcode, and readiness comes back exactly one cycle after the response. The second overlap is between finding a match and issuing the next read. The bench checks it by comparing every lookup's response cycle against a model that counts records, including hits at the first index, hits at the last index and full-table misses.

// File: rtl/op_scan_pkg.sv
package op_scan_pkg;
  // one table record, viewed as the 64-bit memory word
  typedef struct packed {
    logic [31:0] handler;  // bytes 4..7, little-endian
    logic [7:0]  opcode;   // byte 3
    logic [7:0]  spec;     // byte 2
    logic [15:0] lead;     // bytes 0..1, must be zero
  } rec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } scan_st_e;
endpackage

// File: rtl/op_scan_match.sv
module op_scan_match
  import op_scan_pkg::*;
(
  input  logic [63:0] rec_word_i,
  input  logic [7:0]  key_i,
  output logic        hit_o,
  output logic        unsup_o,
  output logic [31:0] handler_o
);
  rec_t rec;

  always_comb begin
    rec       = rec_t'(rec_word_i);
    hit_o     = (rec.opcode == key_i);
    unsup_o   = (rec.spec != 8'd0) || (rec.lead != 16'd0);
    handler_o = rec.handler;
  end
endmodule

// File: rtl/op_scan_ctrl.sv
module op_scan_ctrl
  import op_scan_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 32,
  parameter int unsigned AW = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  parameter int unsigned CW = $clog2(MAX_ENTRIES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [7:0]    req_opcode_i,
  input  logic [CW-1:0] count_i,
  output logic [7:0]    key_o,
  input  logic          hit_i,
  input  logic          unsup_i,
  input  logic [31:0]   handler_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_handler_o,
  output logic          rsp_err_o,
  output logic          rsp_unsup_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_ENTRIES);

  scan_st_e      state_q;
  logic [7:0]    key_q;
  logic [CW-1:0] cnt_q, nxt_q, cnt_eff;
  logic [31:0]   h_q;
  logic          err_q, unsup_q;
  logic          accept, match_now, more;

  always_comb begin
    accept    = req_valid_i && (state_q == ST_IDLE);
    cnt_eff   = (count_i > CNT_MAX) ? CNT_MAX : count_i;
    match_now = (state_q == ST_SCAN) && hit_i;
    more      = (nxt_q < cnt_q);
    rd_en_o   = 1'b0;
    rd_addr_o = '0;
    if (accept && (cnt_eff != '0)) begin
      rd_en_o = 1'b1;
    end else if ((state_q == ST_SCAN) && !match_now && more) begin
      rd_en_o   = 1'b1;
      rd_addr_o = nxt_q[AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
      cnt_q   <= '0;
      nxt_q   <= '0;
      h_q     <= '0;
      err_q   <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          key_q <= req_opcode_i;
          cnt_q <= cnt_eff;
          nxt_q <= CW'(1);
          if (cnt_eff == '0) begin
            state_q <= ST_RESP;
            h_q     <= '0;
            err_q   <= 1'b1;
            unsup_q <= 1'b0;
          end else begin
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (match_now) begin
            state_q <= ST_RESP;
            h_q     <= unsup_i ? 32'd0 : handler_i;
            err_q   <= unsup_i;
            unsup_q <= unsup_i;
          end else if (!more) begin
            state_q <= ST_RESP;
            h_q     <= '0;
            err_q   <= 1'b1;
            unsup_q <= 1'b0;
          end else begin
            nxt_q <= nxt_q + CW'(1);
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = (state_q == ST_RESP);
  assign rsp_handler_o = h_q;
  assign rsp_err_o     = err_q;
  assign rsp_unsup_o   = unsup_q;
  assign key_o         = key_q;
endmodule

// File: rtl/op_dispatch_scan.sv
module op_dispatch_scan #(
  parameter int unsigned MAX_ENTRIES = 32,
  localparam int unsigned AW = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int unsigned CW = $clog2(MAX_ENTRIES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [7:0]    req_opcode_i,
  input  logic [CW-1:0] entry_count_i,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic [63:0]   mem_rd_data_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_handler_o,
  output logic          rsp_err_o,
  output logic          rsp_unsup_o
);
  logic [7:0]  key;
  logic        hit, unsup;
  logic [31:0] handler;

  op_scan_match u_match (
    .rec_word_i (mem_rd_data_i),
    .key_i      (key),
    .hit_o      (hit),
    .unsup_o    (unsup),
    .handler_o  (handler)
  );

  op_scan_ctrl #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .AW          (AW),
    .CW          (CW)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_opcode_i  (req_opcode_i),
    .count_i       (entry_count_i),
    .key_o         (key),
    .hit_i         (hit),
    .unsup_i       (unsup),
    .handler_i     (handler),
    .rd_en_o       (mem_rd_en_o),
    .rd_addr_o     (mem_rd_addr_o),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_handler_o (rsp_handler_o),
    .rsp_err_o     (rsp_err_o),
    .rsp_unsup_o   (rsp_unsup_o)
  );
endmodule

// File: rtl/op_dispatch_scan_chk.sv
module op_dispatch_scan_chk #(
  parameter int unsigned MAX_ENTRIES = 32,
  localparam int unsigned AW = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          mem_rd_en_o,
  input logic [AW-1:0] mem_rd_addr_o,
  input logic          rsp_valid_o,
  input logic [31:0]   rsp_handler_o,
  input logic          rsp_err_o,
  input logic          rsp_unsup_o
);
  p_first_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && mem_rd_en_o) |-> (mem_rd_addr_o == '0));

  p_read_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_en_o && !req_ready_o) |->
      ($past(mem_rd_en_o) && (mem_rd_addr_o == AW'($past(mem_rd_addr_o) + 1'b1))));

  p_no_read_in_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_rd_en_o);

  p_unsup_is_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_unsup_o) |-> (rsp_err_o && (rsp_handler_o == 32'd0)));

  p_err_zero_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_handler_o == 32'd0));

  p_rsp_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  p_hold_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_busy_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r9: assert (req_ready_o && !rsp_valid_o && !mem_rd_en_o);
    end
  end
endmodule

bind op_dispatch_scan op_dispatch_scan_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .mem_rd_en_o   (mem_rd_en_o),
  .mem_rd_addr_o (mem_rd_addr_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_handler_o (rsp_handler_o),
  .rsp_err_o     (rsp_err_o),
  .rsp_unsup_o   (rsp_unsup_o)
);

// File: tb/op_dispatch_scan_tb_top.sv
`timescale 1ns/1ps
module op_dispatch_scan_tb_top;
  localparam int unsigned MAXE = 32;
  localparam int unsigned AW   = $clog2(MAXE);
  localparam int unsigned CW   = $clog2(MAXE + 1);
  localparam logic [7:0] OPS [18] = '{8'h41, 8'h43, 8'h44, 8'h46, 8'h47, 8'h49,
                                      8'h67, 8'h68, 8'h74, 8'h79, 8'h7a, 8'h7c,
                                      8'h7d, 8'h7e, 8'h92, 8'hb8, 8'hbb, 8'he7};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [7:0]    req_opcode = '0;
  logic [CW-1:0] entry_count = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [63:0]   mem_rd_data = '0;
  logic          rsp_valid, rsp_err, rsp_unsup;
  logic [31:0]   rsp_handler;
  logic [63:0]   tbl [MAXE];

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= tbl[mem_rd_addr];

  op_dispatch_scan #(.MAX_ENTRIES(MAXE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_opcode_i(req_opcode),
    .entry_count_i(entry_count),
    .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr), .mem_rd_data_i(mem_rd_data),
    .rsp_valid_o(rsp_valid), .rsp_handler_o(rsp_handler),
    .rsp_err_o(rsp_err), .rsp_unsup_o(rsp_unsup)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [7:0] spec,
                                     input logic [31:0] h);
    return {h, op, spec, 16'h0000};
  endfunction

  // One lookup, compared against the model on every cycle until readiness returns.
  task automatic lookup(input logic [7:0] op, input int cnt, input string req,
                        input bit hold = 1'b0, input logic [7:0] op2 = 8'h00);
    int k = -1;
    int eff = (cnt > int'(MAXE)) ? int'(MAXE) : cnt;
    int lat;
    logic        e_err, e_uns;
    logic [31:0] e_h;
    for (int i = 0; i < eff; i++) begin
      if (tbl[i][31:24] == op) begin k = i; break; end
    end
    lat   = (k >= 0) ? k + 2 : eff + 1;
    e_uns = (k >= 0) && (tbl[k][23:0] != 24'd0);
    e_err = (k < 0) || e_uns;
    e_h   = e_err ? 32'd0 : tbl[k][63:32];

    entry_count = CW'(cnt);
    req_opcode  = op;
    check(req_ready == 1'b1, "R8", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    if (hold) req_opcode = op2;
    else req_valid = 1'b0;
    for (int i = 1; i <= lat; i++) begin
      check(rsp_valid == (i == lat), "R7", $sformatf("rsp_valid op %0h cycle %0d", op, i),
            64'(rsp_valid), 64'(i == lat));
      check(req_ready == 1'b0, "R8", $sformatf("ready busy op %0h cycle %0d", op, i),
            64'(req_ready), 64'd0);
      if (i == lat) begin
        check(rsp_handler == e_h, req, $sformatf("handler op %0h", op),
              64'(rsp_handler), 64'(e_h));
        check(rsp_err == e_err, req, $sformatf("err op %0h", op), 64'(rsp_err), 64'(e_err));
        check(rsp_unsup == e_uns, req, $sformatf("unsup op %0h", op),
              64'(rsp_unsup), 64'(e_uns));
      end
      @(negedge clk);
    end
    check(req_ready == 1'b1, "R8", "ready after response", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R7", "single response cycle", 64'(rsp_valid), 64'd0);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    for (int i = 0; i < int'(MAXE); i++) tbl[i] = mk(8'h3c, 8'h00, 32'h3c3c_0000 + 32'(i));
    for (int i = 0; i < 18; i++) tbl[i] = mk(OPS[i], 8'h00, 32'h0100_0000 + 32'(i) * 32'h0000_0a4c);
    tbl[2]  = mk(8'h44, 8'h00, tbl[1][63:32]);          // alias of 0x43
    tbl[18] = mk(8'h55, 8'h01, 32'h0200_0018);           // non-zero spec
    tbl[19] = mk(8'h41, 8'h00, 32'hdead_0000);           // later duplicate
    tbl[20] = mk(8'hf0, 8'h00, 32'h0300_0020);           // beyond count 20
    tbl[21] = {32'h0400_0021, 8'h56, 8'h00, 16'h0001};   // non-zero lead byte

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "reset ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R9", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check(mem_rd_en == 1'b0, "R9", "reset rd_en", 64'(mem_rd_en), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 18; i++) lookup(OPS[i], 18, (i == 1 || i == 2) ? "R4" : "R1");
    lookup(8'h44, 18, "R4");
    lookup(8'h43, 18, "R4");
    lookup(8'hf0, 18, "R6");
    lookup(8'h00, 18, "R6");
    lookup(8'hff, 18, "R6");
    lookup(8'h8e, 18, "R6");
    lookup(8'h41, 0, "R6");
    lookup(8'hf0, 20, "R2");
    lookup(8'hf0, 21, "R2");
    lookup(8'he7, 17, "R2");
    lookup(8'h77, 40, "R2");   // clamped to MAXE
    lookup(8'h41, 20, "R3");
    lookup(8'h55, 19, "R5");
    lookup(8'h56, 22, "R5");
    lookup(8'h92, 18, "R8", 1'b1, 8'h41);
    lookup(8'hf0, 18, "R8", 1'b1, 8'h46);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule